// File: doc/BRIEF.md
# Power-On Acknowledge Sequencer

This block is the start-up controller of a power-management device that runs in hold-pin acknowledge mode. It runs from a slow (nominally 32 kHz) clock. When an ON request arrives while the device is off, it enables the power-up sequencer for a programmable number of cycles. It keeps the system reset output low during that time. When the sequence ends, it releases the reset output and enters a timed acknowledge window.

The host must drive the hold input high and keep it high. If the hold input is low when the window ends, the block shuts the device down by itself. If the hold input is high at that moment, the device stays on for as long as the hold input stays high. A falling edge on the synchronized hold input, inside or after the window, is an off request and starts power-down at once. Power-down pulls reset low in its first cycle and enables the power-down sequencer for a programmable number of cycles. It then returns to off and marks the return with a one-cycle pulse. The block has only plain control and status pins; it has no streaming interface.

Top module: `pwr_ack_seq`

## Requirements
- R1: While reset is applied and just after it, `state_o` is 0 (off), and `reset_out`, `seq_up_en`, `seq_dn_en` and `off_pulse` are all low.
- R2: In off, a high `on_req` sampled at a rising edge moves the block to power-up (`state_o`=1) at that edge. Power-up lasts max(`up_len`,1) cycles, and `seq_up_en` is high exactly while in power-up.
- R3: `reset_out` is high only in the two active states (window `state_o`=2, held `state_o`=3). It rises in the same cycle the window is entered from power-up.
- R4: The window lasts exactly WINDOW_CYCLES cycles. At its last edge the block goes to held if the synchronized hold level is high, and to power-down (`state_o`=4) if it is low.
- R5: In held, the block stays in held until a falling edge of the synchronized hold level occurs.
- R6: The hold input passes through a two-flop synchronizer. A high-to-low change of `hold_in` during window or held puts the block in power-down on the third rising edge after the change.
- R7: A falling edge of the hold level while in off, power-up or power-down has no effect on the state.
- R8: Power-down lasts max(`down_len`,1) cycles with `reset_out` low from its first cycle and `seq_dn_en` high throughout, then the block returns to off.
- R9: `off_pulse` is high for exactly one cycle, the first off cycle after power-down, and at no other time.
- R10: `on_req` is ignored in power-up, window, held and power-down.
- R11: `state_o` encodes off=0, power-up=1, window=2, held=3, power-down=4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow sequencing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| on_req | input | 1 | ON request, acted on only in off |
| hold_in | input | 1 | Host hold level, asynchronous |
| up_len | input | LEN_W | Power-up sequence length in cycles (0 acts as 1) |
| down_len | input | LEN_W | Power-down sequence length in cycles (0 acts as 1) |
| reset_out | output | 1 | System reset, high means released |
| seq_up_en | output | 1 | Power-up sequencer enable |
| seq_dn_en | output | 1 | Power-down sequencer enable |
| state_o | output | 3 | Current state code |
| off_pulse | output | 1 | One-cycle mark of each return to off |

## Verification
The bound checker checks the following on every cycle: that `reset_out` rises only out of power-up, that it is low on entry to power-down, that an ON request in off always starts power-up, that a detected falling edge in either active state leads to power-down, that held persists without one, and that `off_pulse` only follows power-down. The exact lengths of power-up, the window and power-down cannot be shown by those properties. Nor can the three-edge latency of the hold path, the decision taken at window expiry, or the indifference to hold edges and ON requests in the other states. Only the bench's timed scenarios, compared cycle by cycle against a schedule of expected transitions, can show these.

// File: rtl/pwr_ack_pkg.sv
package pwr_ack_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_PWRUP = 3'd1,
    ST_WIN   = 3'd2,
    ST_HELD  = 3'd3,
    ST_PWRDN = 3'd4
  } pa_state_e;
endpackage

// File: rtl/pwr_ack_hold_sync.sv
module pwr_ack_hold_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_in,
  output logic hold_s,
  output logic fall_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= hold_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign hold_s = sync_q;
  assign fall_o = prev_q & ~sync_q;
endmodule

// File: rtl/pwr_ack_timer.sv
module pwr_ack_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  // The count reaches its last cycle at 1; a loaded 0 also ends after one cycle.
  assign done = (cnt_q <= CNT_W'(1));
endmodule

// File: rtl/pwr_ack_seq.sv
module pwr_ack_seq
  import pwr_ack_pkg::*;
#(
  parameter int WINDOW_CYCLES = 262144,
  parameter int LEN_W         = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             on_req,
  input  logic             hold_in,
  input  logic [LEN_W-1:0] up_len,
  input  logic [LEN_W-1:0] down_len,
  output logic             reset_out,
  output logic             seq_up_en,
  output logic             seq_dn_en,
  output logic [2:0]       state_o,
  output logic             off_pulse
);
  localparam int WIN_W = $clog2(WINDOW_CYCLES + 1);
  localparam int CNT_W = (WIN_W > LEN_W) ? WIN_W : LEN_W;

  pa_state_e        st_q, st_n;
  logic             hold_s, hold_fall;
  logic             tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;

  pwr_ack_hold_sync u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold_in (hold_in),
    .hold_s  (hold_s),
    .fall_o  (hold_fall)
  );

  pwr_ack_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      ST_OFF:   if (on_req) st_n = ST_PWRUP;
      ST_PWRUP: if (tmr_done) st_n = ST_WIN;
      ST_WIN: begin
        if (hold_fall)     st_n = ST_PWRDN;
        else if (tmr_done) st_n = hold_s ? ST_HELD : ST_PWRDN;
      end
      ST_HELD:  if (hold_fall) st_n = ST_PWRDN;
      ST_PWRDN: if (tmr_done) st_n = ST_OFF;
      default:  st_n = ST_OFF;
    endcase
  end

  // Each timed state loads its own length on entry.
  always_comb begin
    tmr_load = (st_n != st_q);
    unique case (st_n)
      ST_PWRUP: tmr_val = CNT_W'(up_len);
      ST_WIN:   tmr_val = CNT_W'(WINDOW_CYCLES);
      ST_PWRDN: tmr_val = CNT_W'(down_len);
      default:  tmr_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_OFF;
      off_pulse <= 1'b0;
    end else begin
      st_q      <= st_n;
      off_pulse <= (st_q == ST_PWRDN) && (st_n == ST_OFF);
    end
  end

  assign reset_out = (st_q == ST_WIN) || (st_q == ST_HELD);
  assign seq_up_en = (st_q == ST_PWRUP);
  assign seq_dn_en = (st_q == ST_PWRDN);
  assign state_o   = st_q;
endmodule

// File: rtl/pwr_ack_seq_chk.sv
module pwr_ack_seq_chk
  import pwr_ack_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       on_req,
  input logic [2:0] state_o,
  input logic       reset_out,
  input logic       seq_up_en,
  input logic       seq_dn_en,
  input logic       off_pulse,
  input logic       hold_fall
);
  a_r1_on_starts_up: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_OFF && on_req) |=> (state_o == ST_PWRUP));

  a_r3_release_after_up: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_out) |-> $past(seq_up_en));

  a_r8_dn_reset_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_dn_en) |-> !reset_out);

  a_r6_fall_powers_down: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_o == ST_WIN || state_o == ST_HELD) && hold_fall) |=> (state_o == ST_PWRDN));

  a_r5_held_persists: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_HELD && !hold_fall) |=> (state_o == ST_HELD));

  a_r9_pulse_after_down: assert property (@(posedge clk) disable iff (!rst_n)
    off_pulse |-> (state_o == ST_OFF && $past(state_o) == ST_PWRDN));

  a_r10_up_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_PWRUP) |=> (state_o == ST_PWRUP || state_o == ST_WIN));

  a_r11_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    state_o <= 3'd4);
endmodule

bind pwr_ack_seq pwr_ack_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .on_req    (on_req),
  .state_o   (state_o),
  .reset_out (reset_out),
  .seq_up_en (seq_up_en),
  .seq_dn_en (seq_dn_en),
  .off_pulse (off_pulse),
  .hold_fall (hold_fall)
);

// File: tb/pwr_ack_seq_tb.sv
`timescale 1ns/1ps
module pwr_ack_seq_tb;
  localparam int W  = 40;
  localparam int LW = 6;

  logic clk = 1'b0, rst_n = 1'b0, on_req = 1'b0, hold_in = 1'b0;
  logic [LW-1:0] up_len = '0, down_len = '0;
  logic reset_out, seq_up_en, seq_dn_en, off_pulse;
  logic [2:0] state_o;

  int cyc = 0, errors = 0, checks = 0;
  bit finished = 0;

  typedef struct { logic [2:0] st; int at; } exp_t;
  exp_t exq[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwr_ack_seq #(.WINDOW_CYCLES(W), .LEN_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .on_req(on_req), .hold_in(hold_in),
    .up_len(up_len), .down_len(down_len), .reset_out(reset_out),
    .seq_up_en(seq_up_en), .seq_dn_en(seq_dn_en), .state_o(state_o),
    .off_pulse(off_pulse)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  task automatic push(logic [2:0] st, int at);
    exp_t e;
    e.st = st; e.at = at;
    exq.push_back(e);
  endtask

  task automatic wait_to(int c);
    while (cyc < c) @(negedge clk);
  endtask

  // Monitor: transitions against the scoreboard, output rules each cycle.
  logic [2:0] last_st = 3'd0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (state_o != last_st) begin
        if (exq.size() == 0) chk(0, "R10 unexpected transition", state_o, last_st);
        else begin
          exp_t e;
          e = exq.pop_front();
          chk(state_o == e.st, "R2/R4/R8 next state", state_o, e.st);
          chk(cyc == e.at, "R2/R4/R6/R8 transition cycle", cyc, e.at);
        end
      end
      chk(reset_out == (state_o == 3'd2 || state_o == 3'd3), "R3 reset_out", reset_out, !reset_out);
      chk(seq_up_en == (state_o == 3'd1), "R2 seq_up_en", seq_up_en, !seq_up_en);
      chk(seq_dn_en == (state_o == 3'd4), "R8 seq_dn_en", seq_dn_en, !seq_dn_en);
      chk(off_pulse == (state_o == 3'd0 && last_st == 3'd4), "R9 off_pulse", off_pulse, !off_pulse);
      last_st = state_o;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog expired: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(state_o == 3'd0, "R1 reset state", state_o, 0);
    chk(!reset_out && !seq_up_en && !seq_dn_en && !off_pulse, "R1 outputs low", reset_out, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(state_o == 3'd0, "R1 idle after reset", state_o, 0);

    // A: hold never raised, window expires (R4), on_req in power-up ignored (R10).
    n = cyc; up_len = 6'd5; down_len = 6'd3; on_req = 1;
    push(3'd1, n+1); push(3'd2, n+6); push(3'd4, n+46); push(3'd0, n+49);
    @(negedge clk); on_req = 0;
    wait_to(n+3); on_req = 1; @(negedge clk); on_req = 0;
    wait_to(n+60);
    chk(state_o == 3'd0, "R8 back to off", state_o, 0);

    // B: hold high at expiry -> held (R4, R5); on_req in held ignored (R10); fall -> down (R6).
    n = cyc; up_len = 6'd2; down_len = 6'd2; on_req = 1;
    push(3'd1, n+1); push(3'd2, n+3); push(3'd3, n+43);
    @(negedge clk); on_req = 0;
    wait_to(n+10); hold_in = 1;
    wait_to(n+50); on_req = 1; @(negedge clk); on_req = 0;
    wait_to(n+58);
    chk(state_o == 3'd3, "R5 still held", state_o, 3);
    wait_to(n+60); hold_in = 0;
    push(3'd4, n+63); push(3'd0, n+65);
    wait_to(n+75);

    // C: falling edge inside the window (R6).
    n = cyc; up_len = 6'd3; down_len = 6'd4; on_req = 1;
    push(3'd1, n+1); push(3'd2, n+4); push(3'd4, n+23); push(3'd0, n+27);
    @(negedge clk); on_req = 0;
    wait_to(n+2); hold_in = 1;
    wait_to(n+20); hold_in = 0;
    wait_to(n+40);

    // D: falling edge during power-up ignored (R7); zero down length acts as 1 (R8).
    n = cyc; up_len = 6'd8; down_len = 6'd0; hold_in = 1; on_req = 1;
    push(3'd1, n+1); push(3'd2, n+9); push(3'd4, n+49); push(3'd0, n+50);
    @(negedge clk); on_req = 0;
    wait_to(n+3); hold_in = 0;
    wait_to(n+7);
    chk(state_o == 3'd1, "R7 fall in power-up ignored", state_o, 1);
    wait_to(n+60);

    // E: zero up length acts as 1 (R2).
    n = cyc; up_len = 6'd0; down_len = 6'd1; on_req = 1;
    push(3'd1, n+1); push(3'd2, n+2); push(3'd4, n+42); push(3'd0, n+43);
    @(negedge clk); on_req = 0;
    wait_to(n+50);

    // F: hold toggling while off has no effect (R7).
    hold_in = 1; repeat (5) @(negedge clk);
    hold_in = 0; repeat (6) @(negedge clk);
    chk(state_o == 3'd0, "R7 fall in off ignored", state_o, 0);
    chk(exq.size() == 0, "R11 all expected transitions seen", exq.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule